// File: doc/BRIEF.md
# Deferred Floating-Point Exception Bounce Controller

This block sits beside the decode stage of a floating-point coprocessor. It decides whether each issued instruction is accepted or bounced to software support code. An arithmetic instruction can arrive flagged as potentially exceptional. That flag comes from an early look at operand exponents and signs, and it is raised whenever overflow or underflow is possible, even when neither would actually occur. Such an instruction completes normally. The controller then raises an exception-pending bit and keeps a copy of the instruction. If the instruction is a short-vector operation, the register fields of the copy are rewritten to name the exact iteration that raised the flag.

While the pending bit is set, the next issued instruction becomes the trigger. It is bounced in its own decode cycle and leaves all state untouched, so it can be retried after the handler returns. Register-transfer instructions that reach the exception control register, the capture register or the identification register are exempt and never act as triggers. This lets support code inspect and clear the state. Illegal operations bounce at once, whatever the pending state. When default-NaN and flush-to-zero are both on and every trap enable is clear, legal work never bounces and the pending bit is not set.

Top module: `fpx_bounce_ctl`

## Requirements
- R1: After reset, `exc_pend` is 0, `cap_insn` is 0, and with no issue `bounce` and `iss_ok` are 0.
- R2: An accepted non-transfer instruction with `iss_pexc` high, outside the fast mode of R8, sets `exc_pend` on the next clock edge and stores the instruction (after R6 rewriting) in `cap_insn`.
- R3: While `exc_pend` is 1, any issued instruction that is not exempt (R4) drives `bounce` high in the same cycle.
- R4: A transfer (`iss_xfer`=1) is exempt when `iss_xfer_sel` is 0 (identification), 1 (exception control) or 2 (capture). Selector values 3 to 7 are other registers, and they bounce while `exc_pend` is 1.
- R5: A bounced instruction changes nothing. `exc_pend` and `cap_insn` keep their values, any write it carries is dropped, and `xfer_rdata` is 0.
- R6: In the capture, the destination field [15:11] and first source field [20:16] are rewritten when `vec_on`=1. Each is a 5-bit index whose top 2 bits name the bank and whose low 3 bits name the slot. The new slot is (slot + `vec_iter` × step) mod 8, where step is 1 when `vec_step2`=0 and 2 when `vec_step2`=1, and the bank bits are kept. The second source field [4:0] is rewritten the same way only when its bank is nonzero. All other bits are copied. With `vec_on`=0 the copy is verbatim.
- R7: An issued instruction with `iss_illegal` high always bounces, even with `exc_pend` at 0 or for an exempt transfer.
- R8: With `md_dnan`=1, `md_ftz`=1 and `md_trap_en`=0, `iss_pexc` is ignored and `exc_pend` stays 0.
- R9: An accepted write (`iss_xfer_wr`=1) to selector 1 loads bit 31 of `iss_wdata` into `exc_pend` on the next edge. The next instruction is judged against the new value. An accepted read of selector 1 returns `exc_pend` in bit 31 and zeros elsewhere.
- R10: An accepted write to selector 2 loads `cap_insn` from `iss_wdata`, and a read returns it. A read of selector 0 returns the parameter `ID_VALUE`. A read of selectors 3 to 7 returns 0.
- R11: `iss_ok` is high exactly when `iss_vld` is high and `bounce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_vld | input | 1 | An instruction is in decode this cycle |
| iss_insn | input | INSN_W | Instruction word |
| iss_illegal | input | 1 | Instruction is illegal or undefined |
| iss_pexc | input | 1 | Potentially exceptional prediction |
| iss_xfer | input | 1 | Instruction is a register transfer |
| iss_xfer_wr | input | 1 | Transfer direction, 1 = write |
| iss_xfer_sel | input | SEL_W | Transfer register selector |
| iss_wdata | input | DATA_W | Transfer write data |
| vec_on | input | 1 | Instruction is a short-vector operation |
| vec_step2 | input | 1 | Vector stride, 1 = step of two |
| vec_iter | input | ITER_W | Iteration that raised the prediction |
| md_dnan | input | 1 | Default-NaN mode |
| md_ftz | input | 1 | Flush-to-zero mode |
| md_trap_en | input | XEN_W | Exception trap enables |
| bounce | output | 1 | Reject current instruction to support code |
| iss_ok | output | 1 | Current instruction accepted |
| exc_pend | output | 1 | Exception pending |
| cap_insn | output | INSN_W | Captured instruction |
| xfer_rdata | output | DATA_W | Transfer read data |

## Verification
On every cycle, the checker confirms the bounce conditions for pending state and illegal operations. It also confirms that a bounced cycle leaves the pending bit and the capture unchanged, that a prediction sets the pending bit, that fast mode keeps the bit clear, and that a control write lands on the next edge. The bench's scenarios show the behaviour that depends on data values. These are the vector register rewriting with both strides and a bank-zero scalar operand, the read-back contents of the three exempt registers, and the retry sequence in which a trigger bounces, software clears the bit, and the same instruction is then accepted.

// File: rtl/fpxb_pkg.sv
package fpxb_pkg;
   // transfer register selectors; exemption depends on these values
   localparam int unsigned SEL_ID  = 0;
   localparam int unsigned SEL_CTL = 1;
   localparam int unsigned SEL_CAP = 2;
   localparam int unsigned SEL_EXEMPT_MAX = 2;

   typedef struct packed {
      logic exempt;
      logic bounce;
      logic accept;
      logic hit_id;
      logic hit_ctl;
      logic hit_cap;
   } fpxb_dec_t;
endpackage

// File: rtl/fpxb_decode.sv
module fpxb_decode
   import fpxb_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic             vld,
   input  logic             illegal,
   input  logic             xfer,
   input  logic [SEL_W-1:0] sel,
   input  logic             pend,
   output fpxb_dec_t        dec
);
   localparam int unsigned SEL_N = 1 << SEL_W;

   logic [SEL_N-1:0] sel_hot;

   generate
      for (genvar s = 0; s < SEL_N; s++) begin : g_hot
         assign sel_hot[s] = xfer && (sel == SEL_W'(s));
      end
   endgenerate

   always_comb begin
      dec.hit_id  = sel_hot[SEL_ID];
      dec.hit_ctl = sel_hot[SEL_CTL];
      dec.hit_cap = sel_hot[SEL_CAP];
      dec.exempt  = |sel_hot[SEL_EXEMPT_MAX:0];
      dec.bounce  = vld && (illegal || (pend && !dec.exempt));
      dec.accept  = vld && !dec.bounce;
   end
endmodule

// File: rtl/fpxb_remap.sv
module fpxb_remap #(
   parameter int unsigned INSN_W   = 32,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned BANK_LOG = 3,
   parameter int unsigned ITER_W   = 3,
   parameter int unsigned DST_LSB  = 11,
   parameter int unsigned SA_LSB   = 16,
   parameter int unsigned SB_LSB   = 0
) (
   input  logic [INSN_W-1:0] insn_in,
   input  logic              vec_on,
   input  logic              step2,
   input  logic [ITER_W-1:0] iter,
   output logic [INSN_W-1:0] insn_out
);
   localparam int unsigned NFLD  = 3;
   localparam int unsigned OFS_W = ITER_W + 1;
   localparam int unsigned BNK_W = REG_W - BANK_LOG;

   function automatic int unsigned fld_lsb(input int unsigned k);
      case (k)
         0:       return DST_LSB;
         1:       return SA_LSB;
         default: return SB_LSB;
      endcase
   endfunction

   logic [OFS_W-1:0] ofs;
   logic [REG_W-1:0] fld_new [NFLD];

   assign ofs = step2 ? {iter, 1'b0} : {1'b0, iter};

   generate
      for (genvar k = 0; k < NFLD; k++) begin : g_fld
         localparam int unsigned LSB = fld_lsb(k);
         logic [REG_W-1:0]    old_idx;
         logic [BNK_W-1:0]    bank;
         logic [BANK_LOG-1:0] slot;
         logic [BANK_LOG-1:0] slot_new;
         logic                keep;

         assign old_idx  = insn_in[LSB +: REG_W];
         assign bank     = old_idx[REG_W-1:BANK_LOG];
         assign slot     = old_idx[BANK_LOG-1:0];
         assign slot_new = slot + ofs[BANK_LOG-1:0];

         if (k == NFLD - 1) begin : g_scalar_ok
            // second source in bank zero is a scalar operand
            assign keep = !vec_on || (bank == '0);
         end else begin : g_always_vec
            assign keep = !vec_on;
         end

         assign fld_new[k] = keep ? old_idx : {bank, slot_new};
      end
   endgenerate

   always_comb begin
      insn_out = insn_in;
      for (int k = 0; k < NFLD; k++) begin
         insn_out[fld_lsb(k) +: REG_W] = fld_new[k];
      end
   end
endmodule

// File: rtl/fpxb_state.sv
module fpxb_state #(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_pend,
   input  logic [INSN_W-1:0] cap_next,
   input  logic              wr_ctl,
   input  logic              wr_cap,
   input  logic [DATA_W-1:0] wdata,
   output logic              pend,
   output logic [INSN_W-1:0] cap
);
   localparam int unsigned PEND_BIT = DATA_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (wr_ctl) begin
         pend <= wdata[PEND_BIT];
      end else if (set_pend) begin
         pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= '0;
      end else if (wr_cap) begin
         cap <= wdata[INSN_W-1:0];
      end else if (set_pend) begin
         cap <= cap_next;
      end
   end
endmodule

// File: rtl/fpx_bounce_ctl.sv
module fpx_bounce_ctl
   import fpxb_pkg::*;
#(
   parameter int unsigned INSN_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned ITER_W   = 3,
   parameter int unsigned XEN_W    = 5,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned BANK_LOG = 3,
   parameter int unsigned DST_LSB  = 11,
   parameter int unsigned SA_LSB   = 16,
   parameter int unsigned SB_LSB   = 0,
   parameter logic [31:0] ID_VALUE = 32'h4650_5801
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_vld,
   input  logic [INSN_W-1:0] iss_insn,
   input  logic              iss_illegal,
   input  logic              iss_pexc,
   input  logic              iss_xfer,
   input  logic              iss_xfer_wr,
   input  logic [SEL_W-1:0]  iss_xfer_sel,
   input  logic [DATA_W-1:0] iss_wdata,
   input  logic              vec_on,
   input  logic              vec_step2,
   input  logic [ITER_W-1:0] vec_iter,
   input  logic              md_dnan,
   input  logic              md_ftz,
   input  logic [XEN_W-1:0]  md_trap_en,
   output logic              bounce,
   output logic              iss_ok,
   output logic              exc_pend,
   output logic [INSN_W-1:0] cap_insn,
   output logic [DATA_W-1:0] xfer_rdata
);
   localparam int unsigned PEND_BIT = DATA_W - 1;
   localparam int unsigned ID_W     = (DATA_W < 32) ? DATA_W : 32;

   // elaboration-time parameter checks
   generate
      if (INSN_W > DATA_W) begin : g_bad_insn
         $error("INSN_W must not exceed DATA_W");
      end
      if (REG_W <= BANK_LOG) begin : g_bad_reg
         $error("REG_W must exceed BANK_LOG");
      end
      if (ITER_W + 1 < BANK_LOG) begin : g_bad_iter
         $error("ITER_W too narrow for bank size");
      end
      if (SEL_W < 2) begin : g_bad_sel
         $error("SEL_W must cover three exempt selectors");
      end
      if (DST_LSB + REG_W > INSN_W || SA_LSB + REG_W > INSN_W ||
          SB_LSB + REG_W > INSN_W) begin : g_bad_fld
         $error("register field outside instruction word");
      end
   endgenerate

   fpxb_dec_t        dec;
   logic [INSN_W-1:0] cap_next;
   logic              fast_mode;
   logic              set_pend;
   logic              wr_ctl;
   logic              wr_cap;
   logic              rd_en;

   fpxb_decode #(.SEL_W(SEL_W)) i_dec (
      .vld     (iss_vld),
      .illegal (iss_illegal),
      .xfer    (iss_xfer),
      .sel     (iss_xfer_sel),
      .pend    (exc_pend),
      .dec     (dec)
   );

   fpxb_remap #(
      .INSN_W   (INSN_W),
      .REG_W    (REG_W),
      .BANK_LOG (BANK_LOG),
      .ITER_W   (ITER_W),
      .DST_LSB  (DST_LSB),
      .SA_LSB   (SA_LSB),
      .SB_LSB   (SB_LSB)
   ) i_remap (
      .insn_in  (iss_insn),
      .vec_on   (vec_on),
      .step2    (vec_step2),
      .iter     (vec_iter),
      .insn_out (cap_next)
   );

   assign fast_mode = md_dnan && md_ftz && (md_trap_en == '0);
   assign set_pend  = dec.accept && !iss_xfer && iss_pexc && !fast_mode;
   assign wr_ctl    = dec.accept && iss_xfer_wr && dec.hit_ctl;
   assign wr_cap    = dec.accept && iss_xfer_wr && dec.hit_cap;
   assign rd_en     = dec.accept && iss_xfer && !iss_xfer_wr;

   fpxb_state #(.INSN_W(INSN_W), .DATA_W(DATA_W)) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pend (set_pend),
      .cap_next (cap_next),
      .wr_ctl   (wr_ctl),
      .wr_cap   (wr_cap),
      .wdata    (iss_wdata),
      .pend     (exc_pend),
      .cap      (cap_insn)
   );

   always_comb begin
      xfer_rdata = '0;
      if (rd_en) begin
         if (dec.hit_ctl) begin
            xfer_rdata[PEND_BIT] = exc_pend;
         end else if (dec.hit_cap) begin
            xfer_rdata[INSN_W-1:0] = cap_insn;
         end else if (dec.hit_id) begin
            xfer_rdata[ID_W-1:0] = ID_VALUE[ID_W-1:0];
         end
      end
   end

   assign bounce = dec.bounce;
   assign iss_ok = dec.accept;
endmodule

// File: rtl/fpxb_bounce_chk.sv
module fpxb_bounce_chk #(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned XEN_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iss_vld,
   input logic              iss_illegal,
   input logic              iss_pexc,
   input logic              iss_xfer,
   input logic              iss_xfer_wr,
   input logic [SEL_W-1:0]  iss_xfer_sel,
   input logic [DATA_W-1:0] iss_wdata,
   input logic              md_dnan,
   input logic              md_ftz,
   input logic [XEN_W-1:0]  md_trap_en,
   input logic              bounce,
   input logic              iss_ok,
   input logic              exc_pend,
   input logic [INSN_W-1:0] cap_insn
);
   logic exempt_p;
   logic fast_p;
   assign exempt_p = iss_xfer && (iss_xfer_sel <= SEL_W'(2));
   assign fast_p   = md_dnan && md_ftz && (md_trap_en == '0);

   AST_PEND_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld && exc_pend && !exempt_p |-> bounce);  // R3

   AST_ILLEGAL_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld && iss_illegal |-> bounce);  // R7

   AST_BOUNCE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      bounce |=> $stable(exc_pend) && $stable(cap_insn));  // R5

   AST_PEXC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ok && !iss_xfer && iss_pexc && !fast_p |=> exc_pend);  // R2

   AST_FAST_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_pend && fast_p && !(iss_vld && iss_xfer) |=> !exc_pend);  // R8

   AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ok && iss_xfer && iss_xfer_wr && (iss_xfer_sel == SEL_W'(1))
      |=> exc_pend == $past(iss_wdata[DATA_W-1]));  // R9

   AST_OK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(iss_ok && bounce));  // R11
endmodule

bind fpx_bounce_ctl fpxb_bounce_chk #(
   .INSN_W (INSN_W),
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W),
   .XEN_W  (XEN_W)
) i_chk (.*);

// File: tb/test_fpx_bounce_ctl.sv
`timescale 1ns/1ps
module test_fpx_bounce_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_vld = 0, iss_illegal = 0, iss_pexc = 0;
   logic        iss_xfer = 0, iss_xfer_wr = 0;
   logic [2:0]  iss_xfer_sel = 0;
   logic [31:0] iss_insn = 0, iss_wdata = 0;
   logic        vec_on = 0, vec_step2 = 0;
   logic [2:0]  vec_iter = 0;
   logic        md_dnan = 0, md_ftz = 0;
   logic [4:0]  md_trap_en = 5'h1f;
   logic        bounce, iss_ok, exc_pend;
   logic [31:0] cap_insn, xfer_rdata;

   localparam logic [31:0] IDV = 32'h4650_5801;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // reference model state
   bit          m_pend = 0;
   logic [31:0] m_cap = 0;

   always #2 clk = ~clk;

   fpx_bounce_ctl i_fpx_bounce_ctl (.*);

   function automatic logic [31:0] ref_remap(input logic [31:0] w, input bit v,
                                             input bit s2, input int it);
      int pos [3] = '{11, 16, 0};
      logic [31:0] r = w;
      for (int k = 0; k < 3; k++) begin
         int idx = int'((w >> pos[k]) & 32'h1f);
         int bnk = idx / 8;
         int slt = idx % 8;
         if (v && !(k == 2 && bnk == 0)) slt = (slt + it * (s2 ? 2 : 1)) % 8;
         idx = bnk * 8 + slt;
         r = (r & ~(32'h1f << pos[k])) | (32'(idx) << pos[k]);
      end
      return r;
   endfunction

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one decode cycle: compare, then advance the model at the edge
   task automatic tick(input string tag);
      bit          ex, bnc, ok, fast;
      logic [31:0] rd;
      bit          n_pend;
      logic [31:0] n_cap;
      #1;
      ex   = iss_xfer && iss_xfer_sel <= 2;
      bnc  = iss_vld && (iss_illegal || (m_pend && !ex));
      ok   = iss_vld && !bnc;
      fast = md_dnan && md_ftz && md_trap_en == 0;
      rd   = 0;
      if (ok && iss_xfer && !iss_xfer_wr) begin
         case (iss_xfer_sel)
            3'd0: rd = IDV;
            3'd1: rd = {m_pend, 31'b0};
            3'd2: rd = m_cap;
            default: rd = 0;
         endcase
      end
      cmp(tag, "bounce", 32'(bounce), 32'(bnc));
      cmp(tag, "iss_ok", 32'(iss_ok), 32'(ok));
      cmp(tag, "exc_pend", 32'(exc_pend), 32'(m_pend));
      cmp(tag, "cap_insn", cap_insn, m_cap);
      cmp(tag, "xfer_rdata", xfer_rdata, rd);
      n_pend = m_pend;
      n_cap  = m_cap;
      if (ok && !iss_xfer && iss_pexc && !fast) begin
         n_pend = 1;
         n_cap  = ref_remap(iss_insn, vec_on, vec_step2, int'(vec_iter));
      end
      if (ok && iss_xfer && iss_xfer_wr && iss_xfer_sel == 1) n_pend = iss_wdata[31];
      if (ok && iss_xfer && iss_xfer_wr && iss_xfer_sel == 2) n_cap = iss_wdata;
      @(posedge clk);
      m_pend = n_pend;
      m_cap  = n_cap;
      @(negedge clk);
   endtask

   task automatic idle();
      iss_vld = 0; iss_illegal = 0; iss_pexc = 0; iss_xfer = 0;
      iss_xfer_wr = 0; iss_xfer_sel = 0; iss_wdata = 0; vec_on = 0;
      vec_step2 = 0; vec_iter = 0;
   endtask

   task automatic arith(input logic [31:0] w, input bit px);
      idle(); iss_vld = 1; iss_insn = w; iss_pexc = px;
   endtask

   task automatic xfer(input int sel, input bit wr, input logic [31:0] d);
      idle(); iss_vld = 1; iss_xfer = 1; iss_xfer_sel = 3'(sel);
      iss_xfer_wr = wr; iss_wdata = d;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      idle(); tick("R1");

      arith(32'h1234_5678, 1); tick("R2");          // prediction, scalar
      idle(); tick("R2");
      arith(32'hAAAA_5555, 1); tick("R3");          // trigger bounces
      arith(32'h0000_0001, 0); tick("R5");          // still bouncing
      xfer(0, 0, 0); tick("R10");                   // read id
      xfer(1, 0, 0); tick("R9");                    // read control
      xfer(2, 0, 0); tick("R10");                   // read capture
      xfer(4, 0, 0); tick("R4");                    // other register bounces
      xfer(5, 1, 32'hFFFF_FFFF); tick("R5");        // bounced write dropped
      xfer(2, 1, 32'hCAFE_F00D); tick("R10");       // capture write
      xfer(2, 0, 0); tick("R10");
      xfer(1, 1, 32'h7FFF_FFFF); tick("R9");        // clear
      arith(32'hAAAA_5555, 0); tick("R9");          // retry accepted
      idle(); iss_vld = 1; iss_illegal = 1; tick("R7");
      xfer(1, 0, 0); iss_illegal = 1; tick("R7");

      // vector capture, stride one
      arith(32'h0016_3A0C, 1); vec_on = 1; vec_iter = 5; tick("R6");
      idle(); tick("R6");
      xfer(1, 1, 0); tick("R9");
      // stride two, second source in bank zero
      arith(32'h001F_F805, 1); vec_on = 1; vec_step2 = 1; vec_iter = 3; tick("R6");
      idle(); tick("R6");
      xfer(1, 1, 0); tick("R9");
      // stride two, second source in bank two
      arith(32'h0009_4013, 1); vec_on = 1; vec_step2 = 1; vec_iter = 7; tick("R6");
      xfer(2, 0, 0); tick("R6");
      xfer(1, 1, 0); tick("R9");

      // fast mode
      md_dnan = 1; md_ftz = 1; md_trap_en = 0;
      for (int i = 0; i < 4; i++) begin
         arith(32'h0101_0101 * i, 1); tick("R8");
      end
      xfer(1, 0, 0); tick("R8");
      md_trap_en = 5'h04;
      arith(32'h0F0F_0F0F, 1); tick("R8");          // one enable: sets
      arith(32'h0, 0); tick("R3");
      md_trap_en = 0;
      xfer(1, 1, 0); tick("R9");

      // software restore of pending bit
      xfer(1, 1, 32'h8000_0000); tick("R9");
      arith(32'h1, 0); tick("R3");
      idle(); tick("R11");
      xfer(7, 0, 0); tick("R4");
      xfer(1, 1, 0); tick("R9");
      xfer(6, 0, 0); tick("R10");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule